// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is a 32-pin general-purpose I/O bank that sits behind a plain 32-bit register read/write port. Each pin has three pieces of state: a direction bit, an output data bit and a synchronised input sample. The output data can be replaced in one write. It can also be changed through two atomic ports, where each 1 in the written mask either sets or clears the matching output bit and leaves the other bits alone.

Every pin has four trigger masks, and any combination of them may be enabled. The high-level trigger fires while the pin reads 1. The low-level trigger fires while it reads 0. The rising trigger fires on a 0-to-1 change of the synchronised sample, and the falling trigger fires on a 1-to-0 change. A pin's event is the OR of its enabled triggers.

Events are latched into a status register that software clears by writing 1s, normally by writing back the value it has just read. A single registered interrupt line is the OR over all pins of status AND enable. The parameter `LAYOUT` picks one of two address maps:
- Layout 0 has one enable register that software updates with read-modify-write.
- Layout 1 has separate write-one-to-set and write-one-to-clear enable ports, and it moves the pin registers up by 0x100.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the bank is in this state: direction reads 0xFFFFFFFF, so all pins are inputs and `pin_oe` is 0. Output data, all four trigger masks, enable and status read 0, and `irq` is 0.
- R2: `pin_oe[n]` is the inverse of direction bit n, where 1 means input and 0 means output. `pin_out` always equals the output data register.
- R3: A write to the set-output port ORs the written mask into the output data register. A write to the clear-output port removes the masked bits. Bits written as 0 keep their value.
- R4: Reading the output data register returns the latched value whatever the direction setting.
- R5: Each pin input passes through a two-flop synchroniser. Reading the input register returns the synchronised pin values.
- R6: With the rising trigger enabled, a pin's status bit sets only on a 0-to-1 change of its synchronised sample. A 1-to-0 change sets nothing.
- R7: With the falling trigger enabled, a pin's status bit sets only on a 1-to-0 change of its synchronised sample.
- R8: The high-level trigger fires while the sample is 1, and the low-level trigger fires while it is 0. With both enabled on one pin, the event is permanently true, so its status and interrupt stay set.
- R9: Status bits stay set until a 1 is written to them at the status offset, and bits written as 0 are untouched. When an event and a clear fall in the same cycle, the event wins, so a held level condition survives an acknowledge.
- R10: `irq` is a register fed by the OR of status AND enable. It clears one cycle after the last enabled status bit clears.
- R11: Layout 0 uses these offsets:

  | Offset | Register |
  |---|---|
  | 0x18 | status |
  | 0x1C | enable (replaced on write) |
  | 0x34 | direction |
  | 0x38 | input |
  | 0x3C | output |
  | 0x40 | low-level mask |
  | 0x44 | high-level mask |
  | 0x48 | rising mask |
  | 0x4C | falling mask |
  | 0x90 | clear-output |
  | 0x94 | set-output |

- R12: Layout 1 uses these offsets:
  - status at 0x2C;
  - enable-set at 0x34 and enable-clear at 0x38, each changing only the bits written as 1, and each reading back the enable mask;
  - every other register at its layout-0 offset plus 0x100.
- R13: Undefined offsets behave as follows:
  - A read of an undefined offset returns 0, and so does a read of the set-output or clear-output port.
  - A write to an undefined offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data, combinational, 0 when not reading |
| pin_in | input | PINS | Raw pin levels |
| pin_out | output | PINS | Output data to the pads |
| pin_oe | output | PINS | Per-pin output enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds two copies of the bank, both with PINS=32 and ADDR_W=12: one with LAYOUT=0 and one with LAYOUT=1. The layout-0 copy covers the single replace-on-write enable register, the output ports and every trigger type, including a held level racing an acknowledge. The layout-1 copy brings the set/clear enable ports and the shifted address map within reach. It also checks that offsets valid only in the other layout read as 0.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_STAT,
        REG_EN,
        REG_EN_SET,
        REG_EN_CLR,
        REG_DIR,
        REG_IN,
        REG_OUT,
        REG_LVL_LO,
        REG_LVL_HI,
        REG_RISE,
        REG_FALL,
        REG_OUT_CLR,
        REG_OUT_SET
    } reg_sel_e;

    // Map a byte offset to a register for the chosen layout.
    function automatic reg_sel_e decode_reg(input logic [15:0] a, input int layout);
        logic [15:0] rel;
        rel = (layout == 0) ? a : (a - 16'h0100);
        if (layout == 0) begin
            if (a == 16'h0018) return REG_STAT;
            if (a == 16'h001C) return REG_EN;
        end else begin
            if (a == 16'h002C) return REG_STAT;
            if (a == 16'h0034) return REG_EN_SET;
            if (a == 16'h0038) return REG_EN_CLR;
        end
        case (rel)
            16'h0034: return REG_DIR;
            16'h0038: return REG_IN;
            16'h003C: return REG_OUT;
            16'h0040: return REG_LVL_LO;
            16'h0044: return REG_LVL_HI;
            16'h0048: return REG_RISE;
            16'h004C: return REG_FALL;
            16'h0090: return REG_OUT_CLR;
            16'h0094: return REG_OUT_SET;
            default:  return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
        end
    end

    assign synced = sync_q;
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cur,
    input  logic en_lo,
    input  logic en_hi,
    input  logic en_rise,
    input  logic en_fall,
    output logic evt
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    assign evt = (en_lo   & ~cur)
               | (en_hi   &  cur)
               | (en_rise &  cur & ~prev_q)
               | (en_fall & ~cur &  prev_q);

    // R8
    both_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_lo && en_hi) |-> evt);
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] en,
    output logic [W-1:0] status,
    output logic         irq
);
    logic [W-1:0] status_q;
    logic         irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= (status_q & ~clr) | evt;
            irq_q    <= |(status_q & en);
        end
    end

    assign status = status_q;
    assign irq    = irq_q;

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q) & ~$past(clr) & ~status_q) == '0));
    // R9
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt) & ~status_q) == '0));
    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_q) |-> $past((status_q & en) == '0));
    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past((status_q & en) != '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int PINS   = 32,
    parameter int ADDR_W = 12,
    parameter int LAYOUT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    localparam logic [PINS-1:0] ALL_IN = '1;

    logic [PINS-1:0] dir_q, out_q, en_q;
    logic [PINS-1:0] lo_q, hi_q, rise_q, fall_q;
    logic [PINS-1:0] pin_s, evt, status, stat_clr;
    logic [15:0]     addr16;
    logic            wr_hit;
    reg_sel_e        sel;

    assign addr16 = 16'(bus_addr);
    assign sel    = decode_reg(addr16, LAYOUT);
    assign wr_hit = bus_sel & bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= ALL_IN;
            out_q  <= '0;
            en_q   <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_hit) begin
            unique case (sel)
                REG_EN:      en_q   <= bus_wdata;
                REG_EN_SET:  en_q   <= en_q | bus_wdata;
                REG_EN_CLR:  en_q   <= en_q & ~bus_wdata;
                REG_DIR:     dir_q  <= bus_wdata;
                REG_OUT:     out_q  <= bus_wdata;
                REG_OUT_SET: out_q  <= out_q | bus_wdata;
                REG_OUT_CLR: out_q  <= out_q & ~bus_wdata;
                REG_LVL_LO:  lo_q   <= bus_wdata;
                REG_LVL_HI:  hi_q   <= bus_wdata;
                REG_RISE:    rise_q <= bus_wdata;
                REG_FALL:    fall_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign stat_clr = (wr_hit && sel == REG_STAT) ? bus_wdata : '0;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (sel)
                REG_STAT:                       bus_rdata = status;
                REG_EN, REG_EN_SET, REG_EN_CLR: bus_rdata = en_q;
                REG_DIR:                        bus_rdata = dir_q;
                REG_IN:                         bus_rdata = pin_s;
                REG_OUT:                        bus_rdata = out_q;
                REG_LVL_LO:                     bus_rdata = lo_q;
                REG_LVL_HI:                     bus_rdata = hi_q;
                REG_RISE:                       bus_rdata = rise_q;
                REG_FALL:                       bus_rdata = fall_q;
                default:                        bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;

    gpio_sync #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (pin_s)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        gpio_pin_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .cur     (pin_s[p]),
            .en_lo   (lo_q[p]),
            .en_hi   (hi_q[p]),
            .en_rise (rise_q[p]),
            .en_fall (fall_q[p]),
            .evt     (evt[p])
        );
    end

    gpio_status #(.W(PINS)) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .clr    (stat_clr),
        .en     (en_q),
        .status (status),
        .irq    (irq)
    );

    // R3
    set_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == REG_OUT_SET) |=> ((out_q & $past(bus_wdata)) == $past(bus_wdata)));
    // R3
    clr_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sel == REG_OUT_CLR) |=> ((out_q & $past(bus_wdata)) == '0));
    // R13
    undef_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && sel == REG_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel0 = 1'b0, sel1 = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata0, rdata1, pout0, pout1, poe0, poe1;
    logic [31:0] pin0 = '0, pin1 = '0;
    logic        irq0, irq1;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    gpio_irq_bank #(.PINS(32), .ADDR_W(12), .LAYOUT(0)) u_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel0), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata0), .pin_in(pin0), .pin_out(pout0),
        .pin_oe(poe0), .irq(irq0));

    gpio_irq_bank #(.PINS(32), .ADDR_W(12), .LAYOUT(1)) u_gpio_irq_bank_alt (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel1), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata1), .pin_in(pin1), .pin_out(pout1),
        .pin_oe(poe1), .irq(irq1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int u, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; sel0 = (u == 0); sel1 = (u == 1);
        @(negedge clk);
        sel0 = 1'b0; sel1 = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_chk(input int u, input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        @(negedge clk);
        addr = a; wr = 1'b0; sel0 = (u == 0); sel1 = (u == 1);
        #1;
        d = (u == 1) ? rdata1 : rdata0;
        sel0 = 1'b0; sel1 = 1'b0;
        chk(tag, d, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk(0, 12'h034, 32'hFFFF_FFFF, "R1 dir");
        rd_chk(0, 12'h03C, 32'h0, "R1 out");
        rd_chk(0, 12'h018, 32'h0, "R1 status");
        rd_chk(0, 12'h01C, 32'h0, "R1 enable");
        rd_chk(0, 12'h040, 32'h0, "R1 lo mask");
        rd_chk(0, 12'h048, 32'h0, "R1 rise mask");
        rd_chk(1, 12'h134, 32'hFFFF_FFFF, "R1 dir alt");
        chk("R1 oe", poe0, 32'h0);
        chk("R1 irq", {31'b0, irq0}, 32'h0);
    endtask

    task automatic t_output;
        bus_write(0, 12'h094, 32'h0000_00F0);
        rd_chk(0, 12'h03C, 32'h0000_00F0, "R3 set");
        bus_write(0, 12'h094, 32'h0F00_0001);
        rd_chk(0, 12'h03C, 32'h0F00_00F1, "R3 set keeps");
        bus_write(0, 12'h090, 32'h0000_0011);
        rd_chk(0, 12'h03C, 32'h0F00_00E0, "R3 clear");
        chk("R2 pin_out", pout0, 32'h0F00_00E0);
        chk("R4 oe while input", poe0, 32'h0);
        bus_write(0, 12'h034, 32'hFFFF_0000);
        chk("R2 oe", poe0, 32'h0000_FFFF);
        rd_chk(0, 12'h03C, 32'h0F00_00E0, "R4 out after dir");
    endtask

    task automatic t_input;
        @(negedge clk); pin0 = 32'hA5A5_0F0F;
        idle(3);
        rd_chk(0, 12'h038, 32'hA5A5_0F0F, "R5 input");
        @(negedge clk); pin0 = '0;
        idle(4);
        rd_chk(0, 12'h038, 32'h0, "R5 input zero");
        rd_chk(0, 12'h018, 32'h0, "R5 no masks no status");
    endtask

    task automatic t_edges;
        bus_write(0, 12'h048, 32'h0000_0008);
        bus_write(0, 12'h01C, 32'h0000_0008);
        @(negedge clk); pin0[3] = 1'b1;
        idle(5);
        rd_chk(0, 12'h018, 32'h0000_0008, "R6 rise status");
        chk("R10 irq set", {31'b0, irq0}, 32'h1);
        bus_write(0, 12'h018, 32'h0000_0008);
        chk("R10 irq one cycle after clear", {31'b0, irq0}, 32'h1);
        @(negedge clk);
        chk("R10 irq low", {31'b0, irq0}, 32'h0);
        rd_chk(0, 12'h018, 32'h0, "R9 ack cleared");
        @(negedge clk); pin0[3] = 1'b0;
        idle(5);
        rd_chk(0, 12'h018, 32'h0, "R6 falling ignored by rise");
        bus_write(0, 12'h04C, 32'h0000_0020);
        @(negedge clk); pin0[5] = 1'b1;
        idle(5);
        rd_chk(0, 12'h018, 32'h0, "R7 rising ignored by fall");
        @(negedge clk); pin0[5] = 1'b0;
        idle(5);
        rd_chk(0, 12'h018, 32'h0000_0020, "R7 fall status");
        chk("R10 not enabled no irq", {31'b0, irq0}, 32'h0);
        bus_write(0, 12'h018, 32'h0000_0020);
        bus_write(0, 12'h048, 32'h0);
        bus_write(0, 12'h04C, 32'h0);
    endtask

    task automatic t_levels;
        bus_write(0, 12'h044, 32'h0000_0100);
        @(negedge clk); pin0[8] = 1'b1;
        idle(4);
        rd_chk(0, 12'h018, 32'h0000_0100, "R8 high level");
        bus_write(0, 12'h018, 32'h0000_0100);
        rd_chk(0, 12'h018, 32'h0000_0100, "R9 event wins over clear");
        bus_write(0, 12'h018, 32'h0);
        rd_chk(0, 12'h018, 32'h0000_0100, "R9 zero bits untouched");
        @(negedge clk); pin0[8] = 1'b0;
        idle(4);
        bus_write(0, 12'h018, 32'h0000_0100);
        rd_chk(0, 12'h018, 32'h0, "R9 clear after level gone");
        bus_write(0, 12'h044, 32'h0);
        bus_write(0, 12'h040, 32'h0000_0200);
        idle(1);
        rd_chk(0, 12'h018, 32'h0000_0200, "R8 low level");
        bus_write(0, 12'h040, 32'h0);
        bus_write(0, 12'h018, 32'h0000_0200);
        rd_chk(0, 12'h018, 32'h0, "R9 low cleared");
        bus_write(0, 12'h040, 32'h0000_0400);
        bus_write(0, 12'h044, 32'h0000_0400);
        bus_write(0, 12'h01C, 32'h0000_0400);
        idle(3);
        chk("R8 both levels irq", {31'b0, irq0}, 32'h1);
        @(negedge clk); pin0[10] = 1'b1;
        idle(4);
        bus_write(0, 12'h018, 32'hFFFF_FFFF);
        idle(2);
        chk("R8 both levels irq stays", {31'b0, irq0}, 32'h1);
        rd_chk(0, 12'h018, 32'h0000_0400, "R8 both levels status");
        bus_write(0, 12'h040, 32'h0);
        bus_write(0, 12'h044, 32'h0);
        bus_write(0, 12'h018, 32'hFFFF_FFFF);
        idle(2);
        chk("R10 irq drops", {31'b0, irq0}, 32'h0);
    endtask

    task automatic t_layout0_enable;
        bus_write(0, 12'h01C, 32'h0000_00FF);
        rd_chk(0, 12'h01C, 32'h0000_00FF, "R11 enable write");
        bus_write(0, 12'h01C, 32'h0000_0F00);
        rd_chk(0, 12'h01C, 32'h0000_0F00, "R11 enable replaced");
        rd_chk(0, 12'h02C, 32'h0, "R11 alt status offset unused");
    endtask

    task automatic t_layout1;
        bus_write(1, 12'h034, 32'h0000_0003);
        rd_chk(1, 12'h034, 32'h0000_0003, "R12 enable set");
        bus_write(1, 12'h034, 32'h0000_0010);
        rd_chk(1, 12'h038, 32'h0000_0013, "R12 enable set keeps");
        bus_write(1, 12'h038, 32'h0000_0001);
        rd_chk(1, 12'h034, 32'h0000_0012, "R12 enable clear");
        bus_write(1, 12'h194, 32'h0000_0005);
        rd_chk(1, 12'h13C, 32'h0000_0005, "R12 out shifted");
        chk("R12 pin_out", pout1, 32'h0000_0005);
        rd_chk(1, 12'h03C, 32'h0, "R13 layout0 out offset unused");
        bus_write(1, 12'h148, 32'h0000_0002);
        @(negedge clk); pin1[1] = 1'b1;
        idle(5);
        rd_chk(1, 12'h02C, 32'h0000_0002, "R12 status offset");
        chk("R12 irq", {31'b0, irq1}, 32'h1);
        bus_write(1, 12'h02C, 32'h0000_0002);
        idle(2);
        chk("R12 irq cleared", {31'b0, irq1}, 32'h0);
    endtask

    task automatic t_undef;
        bus_write(0, 12'h190, 32'hFFFF_FFFF);
        rd_chk(0, 12'h03C, 32'h0F00_00E0, "R13 undef write no effect");
        rd_chk(0, 12'h190, 32'h0, "R13 undef read");
        rd_chk(0, 12'h094, 32'h0, "R13 set port reads zero");
        bus_write(0, 12'h1FC, 32'h1234_5678);
        rd_chk(0, 12'h1FC, 32'h0, "R13 undef read2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_output();
        t_input();
        t_edges();
        t_levels();
        t_layout0_enable();
        t_layout1();
        t_undef();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule